// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as packed BCD: seconds, minutes, 24-hour hours, a day-of-week count, day of the month, month and a two-digit year. A built-in prescaler divides the 32,768 Hz clock down to one advance per second. Each field rolls over at its own limit, and a rollover carries into the next field up in the same clock edge. The day-of-month limit follows the month length and leap years.

A host presets the whole calendar with a single load strobe, which writes every field together and restarts the prescaler, so that the first second after a load is a full second. The count enable stops and resumes the prescaler without touching the fields. Leap years are found from the BCD year digits by a divisible-by-four rule, which is correct for years 2000 through 2099.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs read 00:00:00, day-of-week 1, date 01, month 01, year 00.
- R2: Seconds count 00 to 59 and then wrap to 00, carrying one into minutes. Minutes count 00 to 59 and then wrap to 00, carrying one into hours.
- R3: Hours count 00 to 23. The wrap from 23 to 00 advances the date and the day-of-week on the same edge.
- R4: Day-of-week counts 1 to 7 and wraps from 7 to 1.
- R5: Months 04, 06, 09 and 11 end after date 30. Months 01, 03, 05, 07, 08, 10 and 12 end after date 31. When a month ends, the date returns to 01 and the month advances.
- R6: Month 02 ends after date 28, or after date 29 when the BCD year is a multiple of four. The year is a multiple of four when its tens digit is even and its units digit is 0, 4 or 8, or when its tens digit is odd and its units digit is 2 or 6. Year 00 is a leap year.
- R7: Month 12 wraps to 01 and carries into the year. The year wraps from 99 to 00.
- R8: While the count enable is high, the fields advance once every PRESCALE_DIV clocks and `tickOut` pulses high for one cycle before each advance. While the enable is low, neither the fields nor the prescaler move.
- R9: A load writes all seven fields on one edge and clears the prescaler, so that the next advance comes exactly PRESCALE_DIV clocks later. A load that coincides with a tick wins, and the loaded values are not incremented.
- R10: Within a field, a units digit of 9 wraps to 0 and increments the tens digit. For example, 09 becomes 10 and 19 becomes 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32,768 Hz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Count enable for the prescaler |
| loadEn | input | 1 | Load strobe that writes every field |
| ldSec | input | 8 | BCD seconds to load |
| ldMin | input | 8 | BCD minutes to load |
| ldHour | input | 8 | BCD hours to load |
| ldDow | input | 3 | Day-of-week to load (1 to 7) |
| ldDate | input | 8 | BCD day of month to load |
| ldMon | input | 8 | BCD month to load |
| ldYear | input | 8 | BCD two-digit year to load |
| secOut | output | 8 | BCD seconds |
| minOut | output | 8 | BCD minutes |
| hourOut | output | 8 | BCD hours, 24-hour |
| dowOut | output | 3 | Day-of-week |
| dateOut | output | 8 | BCD day of month |
| monOut | output | 8 | BCD month |
| yearOut | output | 8 | BCD year |
| tickOut | output | 1 | One-cycle pulse on the cycle before each advance |

## Verification
The bench loads the calendar one second before each boundary that matters and checks the result after that second. The boundaries are a units-digit carry, hour and midnight carries, the end of a 30-day and of a 31-day month, February in leap and non-leap years with both tens-digit parities, and the December and year-99 wraps. A wrong leap test shows as February 29 appearing in years such as 98 or 10, or missing in 00, 12 or 96. A wrong month table shows as a date of 31 in a short month, or as a month that ends at 30. A load that loses to a simultaneous tick shows as loaded seconds already incremented. A prescaler that is not cleared on load shows as the first second after a load arriving early.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Control-to-datapath strobes for one clock edge
  typedef struct packed {
    logic       load;
    logic       stepSec;
    logic       stepMin;
    logic       stepHour;
    logic       stepDay;
    logic       stepMon;
    logic       stepYear;
    logic [7:0] dateMax;
  } calStrobe_t;

  localparam logic [7:0] BCD_MAX_SEC  = 8'h59;
  localparam logic [7:0] BCD_MAX_MIN  = 8'h59;
  localparam logic [7:0] BCD_MAX_HOUR = 8'h23;
  localparam logic [7:0] BCD_MAX_MON  = 8'h12;
  localparam logic [7:0] BCD_MAX_YEAR = 8'h99;
  localparam logic [2:0] DOW_MAX      = 3'd7;

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] LO_VAL = '0,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             step,
  input  logic [WIDTH-1:0] hiVal,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] incVal;

  generate
    if (WIDTH > 4) begin : g_bcd
      always_comb begin
        if (q[3:0] >= 4'd9) incVal = {q[WIDTH-1:4] + 1'b1, 4'd0};
        else                incVal = {q[WIDTH-1:4], q[3:0] + 4'd1};
      end
    end else begin : g_bin
      assign incVal = q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)      q <= RST_VAL;
    else if (load)  q <= loadVal;
    else if (step)  q <= (q == hiVal) ? LO_VAL : incVal;
  end

  // R9
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> q == $past(loadVal));

  // R2
  wrap_to_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && q == hiVal) |=> q == LO_VAL);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!step && !load) |=> $stable(q));

endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       loadEn,
  input  logic [7:0] secQ,
  input  logic [7:0] minQ,
  input  logic [7:0] hourQ,
  input  logic [7:0] dateQ,
  input  logic [7:0] monQ,
  input  logic [7:0] yearQ,
  output calStrobe_t strobe,
  output logic       tick
);

  localparam int CW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(PRESCALE_DIV - 1);

  logic [CW-1:0] preCnt;
  logic          leapYear;

  // Divisible by four, tested on BCD digits (valid through 2099)
  function automatic logic isLeap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] monthEnd(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN)                 preCnt <= '0;
    else if (loadEn)           preCnt <= '0;
    else if (runEn) begin
      if (preCnt == LAST_CNT)  preCnt <= '0;
      else                     preCnt <= preCnt + 1'b1;
    end
  end

  assign tick     = runEn && (preCnt == LAST_CNT);
  assign leapYear = isLeap(yearQ);

  always_comb begin
    strobe.load     = loadEn;
    strobe.dateMax  = monthEnd(monQ, leapYear);
    strobe.stepSec  = tick && !loadEn;
    strobe.stepMin  = strobe.stepSec  && (secQ  == BCD_MAX_SEC);
    strobe.stepHour = strobe.stepMin  && (minQ  == BCD_MAX_MIN);
    strobe.stepDay  = strobe.stepHour && (hourQ == BCD_MAX_HOUR);
    strobe.stepMon  = strobe.stepDay  && (dateQ == strobe.dateMax);
    strobe.stepYear = strobe.stepMon  && (monQ  == BCD_MAX_MON);
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= LAST_CNT);

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !loadEn) |=> $stable(preCnt));

  // R9
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> preCnt == '0);

  generate
    if (PRESCALE_DIV > 1) begin : g_gap
      // R8
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/rtc_cal_dp.sv
module rtc_cal_dp
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  input  logic [7:0] ldSec,
  input  logic [7:0] ldMin,
  input  logic [7:0] ldHour,
  input  logic [2:0] ldDow,
  input  logic [7:0] ldDate,
  input  logic [7:0] ldMon,
  input  logic [7:0] ldYear,
  output logic [7:0] secQ,
  output logic [7:0] minQ,
  output logic [7:0] hourQ,
  output logic [2:0] dowQ,
  output logic [7:0] dateQ,
  output logic [7:0] monQ,
  output logic [7:0] yearQ
);

  rtc_bcd_field #(.WIDTH(8), .LO_VAL(8'h00), .RST_VAL(8'h00)) secField (
    .clk(clk), .rstN(rstN), .load(strobe.load), .loadVal(ldSec),
    .step(strobe.stepSec), .hiVal(BCD_MAX_SEC), .q(secQ));

  rtc_bcd_field #(.WIDTH(8), .LO_VAL(8'h00), .RST_VAL(8'h00)) minField (
    .clk(clk), .rstN(rstN), .load(strobe.load), .loadVal(ldMin),
    .step(strobe.stepMin), .hiVal(BCD_MAX_MIN), .q(minQ));

  rtc_bcd_field #(.WIDTH(8), .LO_VAL(8'h00), .RST_VAL(8'h00)) hourField (
    .clk(clk), .rstN(rstN), .load(strobe.load), .loadVal(ldHour),
    .step(strobe.stepHour), .hiVal(BCD_MAX_HOUR), .q(hourQ));

  rtc_bcd_field #(.WIDTH(3), .LO_VAL(3'd1), .RST_VAL(3'd1)) dowField (
    .clk(clk), .rstN(rstN), .load(strobe.load), .loadVal(ldDow),
    .step(strobe.stepDay), .hiVal(DOW_MAX), .q(dowQ));

  rtc_bcd_field #(.WIDTH(8), .LO_VAL(8'h01), .RST_VAL(8'h01)) dateField (
    .clk(clk), .rstN(rstN), .load(strobe.load), .loadVal(ldDate),
    .step(strobe.stepDay), .hiVal(strobe.dateMax), .q(dateQ));

  rtc_bcd_field #(.WIDTH(8), .LO_VAL(8'h01), .RST_VAL(8'h01)) monField (
    .clk(clk), .rstN(rstN), .load(strobe.load), .loadVal(ldMon),
    .step(strobe.stepMon), .hiVal(BCD_MAX_MON), .q(monQ));

  rtc_bcd_field #(.WIDTH(8), .LO_VAL(8'h00), .RST_VAL(8'h00)) yearField (
    .clk(clk), .rstN(rstN), .load(strobe.load), .loadVal(ldYear),
    .step(strobe.stepYear), .hiVal(BCD_MAX_YEAR), .q(yearQ));

  // R3
  midnight_dow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDay && !strobe.load) |=> !$stable(dowQ) && !$stable(dateQ));

  // R3
  date_only_midnight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stepDay && !strobe.load) |=> $stable(dateQ) && $stable(dowQ));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       loadEn,
  input  logic [7:0] ldSec,
  input  logic [7:0] ldMin,
  input  logic [7:0] ldHour,
  input  logic [2:0] ldDow,
  input  logic [7:0] ldDate,
  input  logic [7:0] ldMon,
  input  logic [7:0] ldYear,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [2:0] dowOut,
  output logic [7:0] dateOut,
  output logic [7:0] monOut,
  output logic [7:0] yearOut,
  output logic       tickOut
);

  calStrobe_t strobe;

  rtc_cal_ctrl #(.PRESCALE_DIV(PRESCALE_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .loadEn(loadEn),
    .secQ(secOut), .minQ(minOut), .hourQ(hourOut), .dateQ(dateOut),
    .monQ(monOut), .yearQ(yearOut), .strobe(strobe), .tick(tickOut));

  rtc_cal_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ldSec(ldSec), .ldMin(ldMin), .ldHour(ldHour), .ldDow(ldDow),
    .ldDate(ldDate), .ldMon(ldMon), .ldYear(ldYear),
    .secQ(secOut), .minQ(minOut), .hourQ(hourOut), .dowQ(dowOut),
    .dateQ(dateOut), .monQ(monOut), .yearQ(yearOut));

endmodule

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN, runEn, loadEn;
  logic [7:0] ldSec, ldMin, ldHour, ldDate, ldMon, ldYear;
  logic [2:0] ldDow;
  logic [7:0] secOut, minOut, hourOut, dateOut, monOut, yearOut;
  logic [2:0] dowOut;
  logic       tickOut;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  rtc_calendar #(.PRESCALE_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .loadEn(loadEn),
    .ldSec(ldSec), .ldMin(ldMin), .ldHour(ldHour), .ldDow(ldDow),
    .ldDate(ldDate), .ldMon(ldMon), .ldYear(ldYear),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .dowOut(dowOut),
    .dateOut(dateOut), .monOut(monOut), .yearOut(yearOut), .tickOut(tickOut));

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the load done
  task automatic loadAll(input logic [7:0] h, m, s, input logic [2:0] d,
                         input logic [7:0] dt, mo, y);
    ldHour = h; ldMin = m; ldSec = s; ldDow = d;
    ldDate = dt; ldMon = mo; ldYear = y;
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic seconds(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic chkTime(input string req, input logic [7:0] h, m, s);
    chk(req, "hour", hourOut, h);
    chk(req, "min",  minOut,  m);
    chk(req, "sec",  secOut,  s);
  endtask

  task automatic chkDate(input string req, input logic [2:0] d,
                         input logic [7:0] dt, mo, y);
    chk(req, "dow",   {5'd0, dowOut}, {5'd0, d});
    chk(req, "date",  dateOut, dt);
    chk(req, "month", monOut,  mo);
    chk(req, "year",  yearOut, y);
  endtask

  task automatic t_reset;  // R1
    chkTime("R1", 8'h00, 8'h00, 8'h00);
    chkDate("R1", 3'd1, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_prescale;  // R8
    int ticks = 0;
    runEn = 1'b1;
    loadAll(8'h00, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h00);
    repeat (DIV - 1) @(negedge clk);
    chk("R8", "sec before first tick", secOut, 8'h00);
    chk("R8", "tick before first advance", {7'd0, tickOut}, 8'h01);
    @(negedge clk);
    chk("R8", "sec after one second", secOut, 8'h01);
    repeat (3 * DIV) begin
      @(negedge clk);
      if (tickOut) ticks++;
    end
    chk("R8", "tick count in three seconds", 8'(ticks), 8'd3);
    chk("R8", "sec after four seconds", secOut, 8'h04);
    runEn = 1'b0;
    ticks = 0;
    repeat (5 * DIV) begin
      @(negedge clk);
      if (tickOut) ticks++;
    end
    chk("R8", "ticks while disabled", 8'(ticks), 8'd0);
    chk("R8", "sec held while disabled", secOut, 8'h04);
    runEn = 1'b1;
    seconds(1);
    chk("R8", "sec after resume", secOut, 8'h05);
  endtask

  task automatic t_digitCarry;  // R10
    loadAll(8'h08, 8'h19, 8'h09, 3'd2, 8'h09, 8'h03, 8'h09);
    seconds(1);
    chkTime("R10", 8'h08, 8'h19, 8'h10);
    loadAll(8'h09, 8'h19, 8'h59, 3'd2, 8'h09, 8'h03, 8'h09);
    seconds(1);
    chkTime("R10", 8'h09, 8'h20, 8'h00);
  endtask

  task automatic t_minHour;  // R2
    loadAll(8'h12, 8'h59, 8'h59, 3'd3, 8'h14, 8'h05, 8'h24);
    seconds(1);
    chkTime("R2", 8'h13, 8'h00, 8'h00);
    chkDate("R2", 3'd3, 8'h14, 8'h05, 8'h24);
    loadAll(8'h12, 8'h58, 8'h59, 3'd3, 8'h14, 8'h05, 8'h24);
    seconds(1);
    chkTime("R2", 8'h12, 8'h59, 8'h00);
  endtask

  task automatic t_midnight;  // R3, R4
    loadAll(8'h23, 8'h59, 8'h59, 3'd3, 8'h14, 8'h05, 8'h24);
    seconds(1);
    chkTime("R3", 8'h00, 8'h00, 8'h00);
    chkDate("R3", 3'd4, 8'h15, 8'h05, 8'h24);
    loadAll(8'h23, 8'h59, 8'h59, 3'd7, 8'h20, 8'h05, 8'h24);
    seconds(1);
    chkDate("R4", 3'd1, 8'h21, 8'h05, 8'h24);
  endtask

  task automatic t_monthLen;  // R5
    loadAll(8'h23, 8'h59, 8'h59, 3'd2, 8'h30, 8'h04, 8'h24);
    seconds(1);
    chkDate("R5", 3'd3, 8'h01, 8'h05, 8'h24);
    loadAll(8'h23, 8'h59, 8'h59, 3'd2, 8'h30, 8'h11, 8'h24);
    seconds(1);
    chkDate("R5", 3'd3, 8'h01, 8'h12, 8'h24);
    loadAll(8'h23, 8'h59, 8'h59, 3'd2, 8'h30, 8'h03, 8'h24);
    seconds(1);
    chkDate("R5", 3'd3, 8'h31, 8'h03, 8'h24);
    loadAll(8'h23, 8'h59, 8'h59, 3'd2, 8'h31, 8'h08, 8'h24);
    seconds(1);
    chkDate("R5", 3'd3, 8'h01, 8'h09, 8'h24);
  endtask

  task automatic febCase(input logic [7:0] y, input logic [7:0] expDate,
                         input logic [7:0] expMon);
    loadAll(8'h23, 8'h59, 8'h59, 3'd5, 8'h28, 8'h02, y);
    seconds(1);
    chkDate("R6", 3'd6, expDate, expMon, y);
  endtask

  task automatic t_february;  // R6
    febCase(8'h23, 8'h01, 8'h03);
    febCase(8'h24, 8'h29, 8'h02);
    febCase(8'h00, 8'h29, 8'h02);
    febCase(8'h12, 8'h29, 8'h02);
    febCase(8'h96, 8'h29, 8'h02);
    febCase(8'h98, 8'h01, 8'h03);
    febCase(8'h10, 8'h01, 8'h03);
    loadAll(8'h23, 8'h59, 8'h59, 3'd5, 8'h29, 8'h02, 8'h16);
    seconds(1);
    chkDate("R6", 3'd6, 8'h01, 8'h03, 8'h16);
  endtask

  task automatic t_yearWrap;  // R7
    loadAll(8'h23, 8'h59, 8'h59, 3'd7, 8'h31, 8'h12, 8'h99);
    seconds(1);
    chkTime("R7", 8'h00, 8'h00, 8'h00);
    chkDate("R7", 3'd1, 8'h01, 8'h01, 8'h00);
    loadAll(8'h23, 8'h59, 8'h59, 3'd4, 8'h31, 8'h12, 8'h19);
    seconds(1);
    chkDate("R7", 3'd5, 8'h01, 8'h01, 8'h20);
  endtask

  task automatic t_loadPriority;  // R9
    loadAll(8'h10, 8'h20, 8'h30, 3'd2, 8'h11, 8'h06, 8'h33);
    repeat (DIV - 1) @(negedge clk);
    chk("R9", "tick pending at load", {7'd0, tickOut}, 8'h01);
    loadAll(8'h05, 8'h06, 8'h07, 3'd6, 8'h17, 8'h10, 8'h41);
    chkTime("R9", 8'h05, 8'h06, 8'h07);
    chkDate("R9", 3'd6, 8'h17, 8'h10, 8'h41);
    repeat (DIV - 1) @(negedge clk);
    chk("R9", "sec one cycle short of a second", secOut, 8'h07);
    @(negedge clk);
    chk("R9", "sec one full second after load", secOut, 8'h08);
  endtask

  initial begin
    rstN = 1'b0; runEn = 1'b0; loadEn = 1'b0;
    ldSec = '0; ldMin = '0; ldHour = '0; ldDow = '0;
    ldDate = '0; ldMon = '0; ldYear = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_digitCarry();
    t_minHour();
    t_midnight();
    t_monthLen();
    t_february();
    t_yearWrap();
    t_loadPriority();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule